// File: doc/BRIEF.md
# Three-Slot Compressed Instruction Dispatcher

This block sits at the front of a two-lane VLIW core whose program image is compressed: no padding NOPs are stored. Instead, bit 0 of every instruction word says whether it issues together with the instruction that follows it. The block asks the instruction memory for one 64-bit word (two instructions) at a time. It stores the instructions in three fixed 32-bit slots and emits one issue pair per accepted step. The left lane feeds the multiply-accumulate unit and the right lane feeds the load/store unit.

Slots are never moved. A rotating read pointer names the oldest slot, and the pair is assembled from that slot and, when needed, the next one. A serial instruction is placed on the lane its opcode class needs, with an all-zero NOP on the other lane. A one-cycle synchronous flush empties the buffer so that a new stream can start.

Top module: `vliw_slot_dispatch`

## Requirements
- R1: After reset or flush the first accepted memory word fills slots 0 and 1. Bits [31:0] of a memory word hold the earlier instruction in program order and bits [63:32] the later one.
- R2: `fetch_req_o` is high exactly when at least two of the three slots are empty and `flush_i` is low. A memory word is stored only in a cycle where `fetch_req_o` and `fetch_valid_i` are both high.
- R3: Slots are written in the circular order 0,1,2,0,... and instructions issue in program order across the wrap.
- R4: When bit 0 (the parallel bit) of the oldest instruction is 1, the oldest instruction goes out on `issue_left_o` and the next instruction in program order on `issue_right_o`. Both slots are consumed, and the partner's own parallel bit is ignored.
- R5: When the parallel bit of the oldest instruction is 0, exactly one slot is consumed and the other lane carries 32'h0000_0000.
- R6: The read pointer advances by 1 plus the parallel bit, modulo 3. When the buffer becomes empty the pointer returns to slot 0, so an idle block raises `fetch_req_o` and holds `issue_valid_o` low.
- R7: An instruction with parallel bit 1 whose partner has not yet been fetched is not issued: `issue_valid_o` stays low until the partner arrives.
- R8: A serial instruction whose bits [31:30] are 2'b11 (load/store class) is placed on `issue_right_o` with a NOP on `issue_left_o`. Every other serial instruction is placed on `issue_left_o` with a NOP on `issue_right_o`.
- R9: While `issue_valid_o` is high and `issue_ready_i` is low, the pair stays valid and unchanged in the next cycle, and nothing is consumed.
- R10: In a cycle with `flush_i` high, `issue_valid_o` and `fetch_req_o` are low. In the next cycle the buffer is empty with the pointer at slot 0.
- R11: During and right after reset `issue_valid_o` is 0 and `fetch_req_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Synchronous buffer flush |
| fetch_req_o | output | 1 | Memory word may be accepted this cycle |
| fetch_valid_i | input | 1 | Memory word present on fetch_data_i |
| fetch_data_i | input | 64 | Two instructions, earlier one in the low half |
| issue_valid_o | output | 1 | Issue pair present |
| issue_ready_i | input | 1 | Downstream takes the pair this cycle |
| issue_left_o | output | 32 | Multiply-accumulate lane instruction |
| issue_right_o | output | 32 | Load/store lane instruction |

## Verification
Both the issue pair and the fetch request are combinational functions of the stored state and flush. They are therefore due in the same cycle the state is formed: a word accepted on one clock edge can be issued in the cycle that edge begins, and a consumed pair disappears in the cycle after its accepting edge. The bench drives inputs just after the falling edge and samples 1 ns later, well before the rising edge. Occupancy (two per accepted word, minus one or two per accepted pair) is tracked in the bench to predict the request and the issue-valid in that same sampled cycle. A flush is checked in its own cycle and again one cycle later, and a held pair is compared across the stall cycle that follows.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

   localparam int NSLOTS = 3;

   typedef logic [1:0]        slot_idx_t;
   typedef logic [NSLOTS-1:0] slot_mask_t;

   // (s + n) mod 3 for n in 0..2
   function automatic slot_idx_t slot_step(slot_idx_t s, logic [1:0] n);
      logic [2:0] t;
      t = {1'b0, s} + {1'b0, n};
      if (t >= 3'd3) t = t - 3'd3;
      return t[1:0];
   endfunction

   function automatic slot_mask_t slot_bit(slot_idx_t s);
      return slot_mask_t'(1) << s;
   endfunction

endpackage

// File: rtl/vsd_slot_bank.sv
module vsd_slot_bank
   import vsd_pkg::*;
#(
   parameter int INSN_W = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  slot_idx_t         wr_lo_slot,
   input  slot_idx_t         wr_hi_slot,
   input  logic [2*INSN_W-1:0] wr_data,
   output logic [INSN_W-1:0] slots_o [NSLOTS]
);

   for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
      logic [INSN_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_lo_slot == slot_idx_t'(g))
            word_q <= wr_data[INSN_W-1:0];
         else if (wr_en && wr_hi_slot == slot_idx_t'(g))
            word_q <= wr_data[2*INSN_W-1:INSN_W];
      end
      assign slots_o[g] = word_q;
   end

endmodule

// File: rtl/vsd_fill_ctrl.sv
module vsd_fill_ctrl
   import vsd_pkg::*;
(
   input  slot_mask_t valid_i,
   output logic       can_fill_o,
   output slot_idx_t  lo_slot_o,
   output slot_idx_t  hi_slot_o,
   output slot_mask_t fill_mask_o
);

   // Destination chosen from occupancy alone: the free pair right after
   // the single occupied slot, or slots 0/1 when empty.
   always_comb begin
      can_fill_o = 1'b1;
      lo_slot_o  = 2'd0;
      unique case (valid_i)
         3'b000:  lo_slot_o = 2'd0;
         3'b001:  lo_slot_o = 2'd1;
         3'b010:  lo_slot_o = 2'd2;
         3'b100:  lo_slot_o = 2'd0;
         default: can_fill_o = 1'b0;
      endcase
   end

   assign hi_slot_o   = slot_step(lo_slot_o, 2'd1);
   assign fill_mask_o = slot_bit(lo_slot_o) | slot_bit(hi_slot_o);

endmodule

// File: rtl/vsd_issue_sel.sv
module vsd_issue_sel
   import vsd_pkg::*;
#(
   parameter int         INSN_W   = 32,
   parameter int         PAR_BIT  = 0,
   parameter logic [1:0] MEM_OPC  = 2'b11,
   parameter bit         STEER_EN = 1'b1
) (
   input  logic [INSN_W-1:0] slots_i [NSLOTS],
   input  slot_mask_t        valid_i,
   input  slot_idx_t         idx_i,
   output logic              ready_o,
   output logic [INSN_W-1:0] left_o,
   output logic [INSN_W-1:0] right_o,
   output slot_mask_t        consume_o,
   output slot_idx_t         idx_next_o
);

   slot_idx_t         nxt;
   logic [INSN_W-1:0] first, second;
   logic              par, is_mem;

   assign nxt    = slot_step(idx_i, 2'd1);
   assign first  = slots_i[idx_i];
   assign second = slots_i[nxt];
   assign par    = first[PAR_BIT];

   if (STEER_EN) begin : g_steer
      assign is_mem = (first[INSN_W-1:INSN_W-2] == MEM_OPC);
   end else begin : g_nosteer
      assign is_mem = 1'b0;
   end

   assign ready_o    = valid_i[idx_i] && (!par || valid_i[nxt]);
   assign consume_o  = slot_bit(idx_i) | (par ? slot_bit(nxt) : '0);
   assign idx_next_o = slot_step(idx_i, {1'b0, 1'b1} + {1'b0, par});

   always_comb begin
      if (par) begin
         left_o  = first;
         right_o = second;
      end else if (is_mem) begin
         left_o  = '0;
         right_o = first;
      end else begin
         left_o  = first;
         right_o = '0;
      end
   end

endmodule

// File: rtl/vliw_slot_dispatch.sv
module vliw_slot_dispatch
   import vsd_pkg::*;
#(
   parameter int         INSN_W   = 32,
   parameter int         PAR_BIT  = 0,
   parameter logic [1:0] MEM_OPC  = 2'b11,
   parameter bit         STEER_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush_i,
   output logic                fetch_req_o,
   input  logic                fetch_valid_i,
   input  logic [2*INSN_W-1:0] fetch_data_i,
   output logic                issue_valid_o,
   input  logic                issue_ready_i,
   output logic [INSN_W-1:0]   issue_left_o,
   output logic [INSN_W-1:0]   issue_right_o
);

   localparam int FETCH_W = 2 * INSN_W;

   if (INSN_W < 8) begin : g_bad_width
      $error("vliw_slot_dispatch: INSN_W must be at least 8");
   end
   if (PAR_BIT < 0 || PAR_BIT >= INSN_W - 2) begin : g_bad_pbit
      $error("vliw_slot_dispatch: PAR_BIT must lie below the opcode field");
   end

   slot_mask_t        valid_q, valid_d;
   slot_idx_t         idx_q, idx_d;
   logic [INSN_W-1:0] slots [NSLOTS];
   logic              can_fill, sel_ready, fire, fill;
   slot_idx_t         lo_slot, hi_slot, idx_adv;
   slot_mask_t        fill_mask, consume;

   vsd_fill_ctrl i_fill (
      .valid_i     (valid_q),
      .can_fill_o  (can_fill),
      .lo_slot_o   (lo_slot),
      .hi_slot_o   (hi_slot),
      .fill_mask_o (fill_mask)
   );

   vsd_slot_bank #(.INSN_W(INSN_W)) i_bank (
      .clk        (clk),
      .wr_en      (fill),
      .wr_lo_slot (lo_slot),
      .wr_hi_slot (hi_slot),
      .wr_data    (fetch_data_i[FETCH_W-1:0]),
      .slots_o    (slots)
   );

   vsd_issue_sel #(
      .INSN_W   (INSN_W),
      .PAR_BIT  (PAR_BIT),
      .MEM_OPC  (MEM_OPC),
      .STEER_EN (STEER_EN)
   ) i_sel (
      .slots_i    (slots),
      .valid_i    (valid_q),
      .idx_i      (idx_q),
      .ready_o    (sel_ready),
      .left_o     (issue_left_o),
      .right_o    (issue_right_o),
      .consume_o  (consume),
      .idx_next_o (idx_adv)
   );

   assign fetch_req_o   = can_fill && !flush_i;
   assign issue_valid_o = sel_ready && !flush_i;
   assign fill          = fetch_req_o && fetch_valid_i;
   assign fire          = issue_valid_o && issue_ready_i;

   always_comb begin
      valid_d = (valid_q & ~(fire ? consume : '0)) | (fill ? fill_mask : '0);
      idx_d   = fire ? idx_adv : idx_q;
      if (flush_i || valid_d == '0) begin
         valid_d = '0;
         idx_d   = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         idx_q   <= '0;
      end else begin
         valid_q <= valid_d;
         idx_q   <= idx_d;
      end
   end

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker
   import vsd_pkg::*;
#(
   parameter int INSN_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_i,
   input logic              fetch_req_o,
   input logic              fetch_valid_i,
   input logic              issue_valid_o,
   input logic              issue_ready_i,
   input logic [INSN_W-1:0] issue_left_o,
   input logic [INSN_W-1:0] issue_right_o,
   input slot_mask_t        valid_q,
   input slot_idx_t         idx_q
);

   p_fill_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_o |-> ($countones(valid_q) <= 1));

   p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q != 2'd3);

   p_serial_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid_o && issue_left_o != '0 && !issue_left_o[0]) |-> issue_right_o == '0);

   p_empty_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q == '0) |-> idx_q == '0);

   p_right_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid_o && issue_left_o == '0 && issue_right_o != '0)
         |-> issue_right_o[INSN_W-1:INSN_W-2] == 2'b11);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid_o && !issue_ready_i && !flush_i)
         |=> (issue_valid_o || flush_i) && $stable(issue_left_o) && $stable(issue_right_o));

   p_flush_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> (!issue_valid_o && !fetch_req_o));

   p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (valid_q == '0 && idx_q == '0));

   p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_i && !(issue_valid_o && issue_ready_i) && !(fetch_req_o && fetch_valid_i))
         |=> $stable(valid_q) && $stable(idx_q));

endmodule

bind vliw_slot_dispatch vsd_checker #(.INSN_W(INSN_W)) i_vsd_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .flush_i       (flush_i),
   .fetch_req_o   (fetch_req_o),
   .fetch_valid_i (fetch_valid_i),
   .issue_valid_o (issue_valid_o),
   .issue_ready_i (issue_ready_i),
   .issue_left_o  (issue_left_o),
   .issue_right_o (issue_right_o),
   .valid_q       (valid_q),
   .idx_q         (idx_q)
);

// File: tb/test_vliw_slot_dispatch.sv
`timescale 1ns/1ps
module test_vliw_slot_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic        fetch_req_o;
   logic        fetch_valid_i = 1'b0;
   logic [63:0] fetch_data_i = '0;
   logic        issue_valid_o;
   logic        issue_ready_i = 1'b0;
   logic [31:0] issue_left_o, issue_right_o;

   always #2.5 clk = ~clk;

   vliw_slot_dispatch i_vliw_slot_dispatch (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush_i       (flush_i),
      .fetch_req_o   (fetch_req_o),
      .fetch_valid_i (fetch_valid_i),
      .fetch_data_i  (fetch_data_i),
      .issue_valid_o (issue_valid_o),
      .issue_ready_i (issue_ready_i),
      .issue_left_o  (issue_left_o),
      .issue_right_o (issue_right_o)
   );

   int          n_checks = 0;
   int          n_fail   = 0;
   bit          done     = 1'b0;
   logic [31:0] strm [0:255];
   int          slen, fptr, eptr, occ;
   bit          hold_pend, first_fire;
   logic [31:0] hold_l, hold_r;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_insn(bit mem, bit p);
      logic [31:0] r;
      r = $urandom;
      r[31:30] = mem ? 2'b11 : 2'($urandom % 3);
      r[0] = p;
      return r;
   endfunction

   // kind 0 random mix, 1 serial only, 2 pairs straddling words, 3 NOP forms
   task automatic gen(input int n, input int kind);
      int len = 0;
      while (len < n) begin
         bit pair;
         case (kind)
            1: pair = 1'b0;
            2: pair = (len != 0);
            default: pair = ($urandom % 100) < 45;
         endcase
         if (len + 2 > n) pair = 1'b0;
         if (kind == 3) begin
            strm[len] = pair ? 32'h0000_0001 : 32'h0;
            if (pair) strm[len+1] = ($urandom % 2) ? 32'h0 : mk_insn(1'b1, 1'b1);
         end else if (pair) begin
            strm[len]   = mk_insn(($urandom % 3) == 0, 1'b1);
            strm[len+1] = mk_insn(($urandom % 3) == 0, 1'($urandom));
         end else begin
            strm[len] = mk_insn(kind == 1 ? len[1] : (($urandom % 3) == 0), 1'b0);
         end
         len += pair ? 2 : 1;
      end
      slen = n; fptr = 0; eptr = 0; occ = 0; hold_pend = 1'b0;
   endtask

   task automatic exp_pair(output logic [31:0] l, output logic [31:0] r,
                           output int need, output string tag);
      logic [31:0] a;
      a = strm[eptr];
      if (a[0]) begin
         l = a; r = strm[eptr+1]; need = 2; tag = "R3 R4 pair";
      end else if (a[31:30] == 2'b11) begin
         l = 32'h0; r = a; need = 1; tag = "R5 R8 serial load/store";
      end else begin
         l = a; r = 32'h0; need = 1; tag = "R3 R5 R8 serial";
      end
   endtask

   task automatic run(input int vprob, input int rprob, input int maxc);
      for (int c = 0; c < maxc && eptr < slen; c++) begin
         logic [31:0] el, er;
         int          need;
         string       tag;
         @(negedge clk);
         flush_i       = 1'b0;
         fetch_valid_i = (fptr < slen) && (($urandom % 100) < vprob);
         fetch_data_i  = {strm[fptr+1], strm[fptr]};
         issue_ready_i = ($urandom % 100) < rprob;
         #1;
         chk(fetch_req_o == (occ <= 1), "R2 fetch request", 64'(fetch_req_o), 64'(occ <= 1));
         exp_pair(el, er, need, tag);
         chk(issue_valid_o == (occ >= need), "R7 issue valid", 64'(issue_valid_o),
             64'(occ >= need));
         if (hold_pend)
            chk(issue_valid_o && issue_left_o == hold_l && issue_right_o == hold_r,
                "R9 held pair", {issue_left_o, issue_right_o}, {hold_l, hold_r});
         hold_pend = issue_valid_o && !issue_ready_i;
         hold_l = issue_left_o; hold_r = issue_right_o;
         if (issue_valid_o && issue_ready_i) begin
            if (first_fire) tag = {"R1 ", tag};
            first_fire = 1'b0;
            chk(issue_left_o == el && issue_right_o == er, tag,
                {issue_left_o, issue_right_o}, {el, er});
            eptr += need; occ -= need;
         end
         if (fetch_req_o && fetch_valid_i) begin
            fptr += 2; occ += 2;
         end
      end
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      flush_i = 1'b0; fetch_valid_i = 1'b0; issue_ready_i = 1'b0;
      #1;
      chk(!issue_valid_o && fetch_req_o, tag, {issue_valid_o, fetch_req_o}, 2'b01);
   endtask

   task automatic stream(input int n, input int kind, input int vp, input int rp);
      gen(n, kind);
      run(vp, rp, 4000);
      chk(eptr == slen, "R9 stream drained", 64'(eptr), 64'(slen));
      idle_check("R6 empty after drain");
   endtask

   initial begin
      void'($urandom(32'd20240611));
      first_fire = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(!issue_valid_o && fetch_req_o, "R11 in reset", {issue_valid_o, fetch_req_o}, 2'b01);
      rst_n = 1'b1;
      idle_check("R11 after reset");

      stream(24, 1, 100, 100);   // serial only, full rate
      stream(24, 2, 60, 100);    // pairs straddle memory words
      stream(16, 3, 80, 70);     // NOP forms
      stream(40, 0, 100, 30);    // backpressure
      stream(40, 0, 25, 100);    // slow memory
      for (int k = 0; k < 20; k++)
         stream(64, 0, 20 + 4 * k, 100 - 3 * k);

      // flush mid-stream
      gen(64, 0);
      run(70, 60, 25);
      @(negedge clk);
      flush_i = 1'b1; fetch_valid_i = 1'b1; issue_ready_i = 1'b1;
      #1;
      chk(!issue_valid_o && !fetch_req_o, "R10 flush cycle",
          {issue_valid_o, fetch_req_o}, 2'b00);
      idle_check("R6 R10 after flush");
      stream(32, 0, 70, 70);     // restarts at slot 0

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL R9 watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule